// File: doc/BRIEF.md
# Legacy Video Window Router

This block is one decode stage of a host bridge. Every request it is given is tested against the 128 KB legacy video window at A0000h–BFFFFh. A request inside the window is steered to exactly one destination: system DRAM, the default legacy bus port, or one of `N_PORTS` downstream bridge ports. A request outside the window gets no target at all. Each window hit is also flagged non-cacheable.

SMM memory can overlay the window. The decision therefore depends on three things: where the request came from, a per-request SMM-memory qualifier, and the per-port video-enable bits. The qualifier travels on a multiplexed address bit and is valid only in the cycle that carries the request strobe, so the block samples it in that cycle only. The routing result is registered and appears one clock after the strobe. It is held until the next request arrives.

Top module: `legacy_win_router`

## Requirements
- R1: A request hits when its full address lies in A0000h..BFFFFh, both ends included. Any other address, including one with upper bits set, gives `hit_o`=0, `tgt_o`=0 and `nc_o`=0.
- R2: If no bit of `vga_en_i` is set, a window hit that is not routed to DRAM selects the legacy port, which is `tgt_o` bit 1.
- R3: If exactly one bit i of `vga_en_i` is set, a window hit that is not routed to DRAM selects downstream port i, which is `tgt_o` bit 2+i.
- R4: A window hit selects DRAM (`tgt_o` bit 0) only when all three hold: `smm_en_i`=1, `req_from_cpu_i`=1 and `smm_mem_i`=1. If `smm_en_i`=0, the request goes to the video target.
- R5: With `smm_mem_i`=0, a processor window hit goes to the video target even when `smm_en_i`=1.
- R6: A request with `req_from_cpu_i`=0 never selects DRAM. It goes to the video target whatever the values of `smm_mem_i` and `smm_en_i`.
- R7: `smm_mem_i` is sampled only in the cycle in which `req_valid_i`=1. Changes in later cycles have no effect on the held result.
- R8: `nc_o` is 1 exactly when the held result is a window hit.
- R9: The sub-range B0000h–B7FFFh is decoded by the same rules as the rest of the window.
- R10: The outputs change in the first clock after `req_valid_i`=1 and not earlier. While `req_valid_i`=0 they keep their values.
- R11: If more than one `vga_en_i` bit is set, the lowest-numbered enabled port is chosen and `cfg_err_o`=1 for that request. Otherwise `cfg_err_o`=0.
- R12: While `rst_ni`=0, `tgt_o`, `hit_o`, `nc_o` and `cfg_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_addr_i | input | ADDR_W | Request address |
| req_from_cpu_i | input | 1 | 1 = processor origin, 0 = downstream or legacy port |
| smm_mem_i | input | 1 | SMM-memory qualifier, valid with the strobe |
| smm_en_i | input | 1 | SMM space enabled over the window |
| vga_en_i | input | N_PORTS | Video-enable bit for each downstream port |
| tgt_o | output | N_PORTS+2 | One-hot target: bit0 DRAM, bit1 legacy port, bit 2+i port i |
| hit_o | output | 1 | Held result is a window hit |
| nc_o | output | 1 | Held result is non-cacheable |
| cfg_err_o | output | 1 | More than one video-enable bit was set |

## Verification
On every cycle, the assertions check the following:
- at most one target bit is active;
- a miss never selects a target;
- a request from a port never reaches DRAM;
- a qualified SMM request from the processor lands in DRAM;
- a hit is always non-cacheable;
- the outputs stay unchanged between requests.

Only the bench scenarios can show the rest:
- which port wins when several enable bits are set;
- that the error flag is raised in that case;
- that the window boundary addresses decode exactly;
- that the result does not appear in the same cycle as the strobe;
- that a late change of the qualifier is ignored.

// File: rtl/legacy_win_pkg.sv
package legacy_win_pkg;
  localparam logic [19:0] WIN_FIRST = 20'hA0000;
  localparam logic [19:0] WIN_LAST  = 20'hBFFFF;

  localparam int TGT_DRAM   = 0;
  localparam int TGT_LEGACY = 1;
  localparam int TGT_PORT0  = 2;

  typedef enum logic [1:0] {
    RK_NONE   = 2'd0,
    RK_DRAM   = 2'd1,
    RK_LEGACY = 2'd2,
    RK_PORT   = 2'd3
  } route_kind_e;
endpackage

// File: rtl/lw_window_dec.sv
module lw_window_dec
  import legacy_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_FIRST);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_LAST);

  // full-width compare, so upper address bits must be zero
  assign hit_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/lw_vga_pick.sv
module lw_vga_pick #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [N_PORTS-1:0] en_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               multi_o
);
  always_comb begin
    idx_o = '0;
    // scan from high to low so that the lowest set bit is written last
    for (int p = N_PORTS - 1; p >= 0; p--) begin
      if (en_i[p]) idx_o = IDX_W'(p);
    end
  end

  assign any_o   = |en_i;
  assign multi_o = $countones(en_i) > 1;
endmodule

// File: rtl/lw_route_sel.sv
module lw_route_sel
  import legacy_win_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int TGT_W = N_PORTS + 2
) (
  input  logic             hit_i,
  input  logic             from_cpu_i,
  input  logic             smm_mem_i,
  input  logic             smm_en_i,
  input  logic             vga_any_i,
  input  logic [IDX_W-1:0] vga_idx_i,
  output route_kind_e      kind_o,
  output logic [TGT_W-1:0] tgt_o
);
  logic to_dram;

  // port and legacy origins fall through to the video target
  assign to_dram = smm_en_i && from_cpu_i && smm_mem_i;

  always_comb begin
    if (!hit_i)         kind_o = RK_NONE;
    else if (to_dram)   kind_o = RK_DRAM;
    else if (vga_any_i) kind_o = RK_PORT;
    else                kind_o = RK_LEGACY;
  end

  always_comb begin
    tgt_o = '0;
    unique case (kind_o)
      RK_DRAM:   tgt_o[TGT_DRAM]   = 1'b1;
      RK_LEGACY: tgt_o[TGT_LEGACY] = 1'b1;
      RK_PORT: begin
        for (int p = 0; p < N_PORTS; p++) begin
          if (vga_idx_i == IDX_W'(p)) tgt_o[TGT_PORT0 + p] = 1'b1;
        end
      end
      default:   tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/legacy_win_router.sv
module legacy_win_router
  import legacy_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int N_PORTS = 4,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int TGT_W  = N_PORTS + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_from_cpu_i,
  input  logic               smm_mem_i,
  input  logic               smm_en_i,
  input  logic [N_PORTS-1:0] vga_en_i,
  output logic [TGT_W-1:0]   tgt_o,
  output logic               hit_o,
  output logic               nc_o,
  output logic               cfg_err_o
);
  logic             win_hit;
  logic             vga_any;
  logic             vga_multi;
  logic [IDX_W-1:0] vga_idx;
  route_kind_e      kind;
  logic [TGT_W-1:0] tgt_d;

  lw_window_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .hit_o  (win_hit)
  );

  lw_vga_pick #(.N_PORTS(N_PORTS)) u_pick (
    .en_i    (vga_en_i),
    .any_o   (vga_any),
    .idx_o   (vga_idx),
    .multi_o (vga_multi)
  );

  lw_route_sel #(.N_PORTS(N_PORTS)) u_sel (
    .hit_i      (win_hit),
    .from_cpu_i (req_from_cpu_i),
    .smm_mem_i  (smm_mem_i),
    .smm_en_i   (smm_en_i),
    .vga_any_i  (vga_any),
    .vga_idx_i  (vga_idx),
    .kind_o     (kind),
    .tgt_o      (tgt_d)
  );

  // qualifier is only meaningful in the strobe cycle: capture result there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_o     <= '0;
      hit_o     <= 1'b0;
      nc_o      <= 1'b0;
      cfg_err_o <= 1'b0;
    end else if (req_valid_i) begin
      tgt_o     <= tgt_d;
      hit_o     <= kind != RK_NONE;
      nc_o      <= win_hit;
      cfg_err_o <= vga_multi;
    end
  end

  localparam logic [ADDR_W-1:0] CHK_LO = ADDR_W'(WIN_FIRST);
  localparam logic [ADDR_W-1:0] CHK_HI = ADDR_W'(WIN_LAST);
  logic in_win_chk;
  assign in_win_chk = (req_addr_i >= CHK_LO) && (req_addr_i <= CHK_HI);

  AST_TGT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_o)); // R3
  AST_MISS_NO_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !in_win_chk |=> tgt_o == '0 && !hit_o && !nc_o); // R1
  AST_PORT_NOT_DRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_from_cpu_i |=> !tgt_o[TGT_DRAM]); // R6
  AST_SMM_TO_DRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && in_win_chk && smm_en_i && req_from_cpu_i && smm_mem_i
    |=> tgt_o[TGT_DRAM]); // R4
  AST_NO_QUAL_NOT_DRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !smm_mem_i |=> !tgt_o[TGT_DRAM]); // R5
  AST_HIT_NONCACHE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && in_win_chk |=> nc_o && hit_o); // R8
  AST_LEGACY_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && in_win_chk && vga_en_i == '0 && !smm_mem_i
    |=> tgt_o[TGT_LEGACY]); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable({tgt_o, hit_o, nc_o, cfg_err_o})); // R10
endmodule

// File: tb/legacy_win_router_tb.sv
module legacy_win_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int TW = NP + 2;

  localparam logic [TW-1:0] T_NONE = 6'b000000;
  localparam logic [TW-1:0] T_DRAM = 6'b000001;
  localparam logic [TW-1:0] T_LEG  = 6'b000010;
  localparam logic [TW-1:0] T_P0   = 6'b000100;
  localparam logic [TW-1:0] T_P1   = 6'b001000;
  localparam logic [TW-1:0] T_P2   = 6'b010000;
  localparam logic [TW-1:0] T_P3   = 6'b100000;

  typedef struct packed {
    logic [31:0]   addr;
    logic          cpu;
    logic          qual;
    logic          smm;
    logic [NP-1:0] vga;
    logic [TW-1:0] tgt;
    logic          hit;
    logic          err;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h000A0000, 1'b1, 1'b0, 1'b0, 4'b0000, T_LEG,  1'b1, 1'b0, 4'd1},  // R1 low edge
    '{32'h000BFFFF, 1'b0, 1'b0, 1'b0, 4'b0000, T_LEG,  1'b1, 1'b0, 4'd2},  // R2 high edge
    '{32'h0009FFFF, 1'b1, 1'b1, 1'b1, 4'b0000, T_NONE, 1'b0, 1'b0, 4'd1},  // R1 below
    '{32'h000C0000, 1'b1, 1'b0, 1'b0, 4'b0010, T_NONE, 1'b0, 1'b0, 4'd1},  // R1 above
    '{32'h000A8000, 1'b1, 1'b0, 1'b0, 4'b0100, T_P2,   1'b1, 1'b0, 4'd3},  // R3
    '{32'h000A8000, 1'b0, 1'b0, 1'b0, 4'b0001, T_P0,   1'b1, 1'b0, 4'd3},  // R3
    '{32'h000B0000, 1'b1, 1'b0, 1'b0, 4'b1000, T_P3,   1'b1, 1'b0, 4'd9},  // R9
    '{32'h000B7FFF, 1'b1, 1'b1, 1'b1, 4'b0000, T_DRAM, 1'b1, 1'b0, 4'd9},  // R9
    '{32'h000AFFFF, 1'b1, 1'b1, 1'b1, 4'b0010, T_DRAM, 1'b1, 1'b0, 4'd4},  // R4
    '{32'h000AFFFF, 1'b1, 1'b1, 1'b0, 4'b0010, T_P1,   1'b1, 1'b0, 4'd4},  // R4 smm off
    '{32'h000A1234, 1'b1, 1'b0, 1'b1, 4'b0010, T_P1,   1'b1, 1'b0, 4'd5},  // R5
    '{32'h000A1234, 1'b0, 1'b1, 1'b1, 4'b0010, T_P1,   1'b1, 1'b0, 4'd6},  // R6
    '{32'h000BC000, 1'b0, 1'b1, 1'b1, 4'b0000, T_LEG,  1'b1, 1'b0, 4'd6},  // R6
    '{32'h000A0000, 1'b1, 1'b0, 1'b0, 4'b0110, T_P1,   1'b1, 1'b1, 4'd11}, // R11
    '{32'h000A0000, 1'b1, 1'b1, 1'b1, 4'b1111, T_DRAM, 1'b1, 1'b1, 4'd11}, // R11
    '{32'h100A0000, 1'b1, 1'b0, 1'b0, 4'b0000, T_NONE, 1'b0, 1'b0, 4'd1}   // R1 upper bits
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          req_cpu = 1'b0;
  logic          qual = 1'b0;
  logic          smm_en = 1'b0;
  logic [NP-1:0] vga_en = '0;
  logic [TW-1:0] tgt;
  logic          hit, nc, cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  legacy_win_router #(.ADDR_W(32), .N_PORTS(NP)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_addr_i     (req_addr),
    .req_from_cpu_i (req_cpu),
    .smm_mem_i      (qual),
    .smm_en_i       (smm_en),
    .vga_en_i       (vga_en),
    .tgt_o          (tgt),
    .hit_o          (hit),
    .nc_o           (nc),
    .cfg_err_o      (cfg_err)
  );

  task automatic expect_out(string tag, logic [TW-1:0] e_tgt, logic e_hit, logic e_err);
    n_chk++;
    if (tgt !== e_tgt || hit !== e_hit || nc !== e_hit || cfg_err !== e_err) begin
      n_bad++;
      $display("FAIL %s: tgt=%b hit=%b nc=%b err=%b expected tgt=%b hit=%b nc=%b err=%b",
               tag, tgt, hit, nc, cfg_err, e_tgt, e_hit, e_hit, e_err);
    end
  endtask

  task automatic drive(logic [31:0] a, logic c, logic q, logic s, logic [NP-1:0] v);
    @(negedge clk);
    req_addr = a; req_cpu = c; qual = q; smm_en = s; vga_en = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    expect_out("R12 reset", T_NONE, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].addr, VECS[i].cpu, VECS[i].qual, VECS[i].smm, VECS[i].vga);
      expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                 VECS[i].tgt, VECS[i].hit, VECS[i].err);
    end

    // R10: the result is held while the strobe stays low
    drive(32'h000A4000, 1'b1, 1'b0, 1'b0, 4'b1000);
    req_addr = 32'h00050000; vga_en = 4'b0001; req_cpu = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R10 hold", T_P3, 1'b1, 1'b0);

    // R10: nothing changes before the clock edge that captures the strobe
    req_addr = 32'h000A4000; req_cpu = 1'b1; qual = 1'b1; smm_en = 1'b1; vga_en = '0;
    req_valid = 1'b1;
    #1;
    expect_out("R10 no early change", T_P3, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    expect_out("R10 one clock later", T_DRAM, 1'b1, 1'b0);

    // R7: a late qualifier change is ignored
    qual = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R7 late qualifier", T_DRAM, 1'b1, 1'b0);
    drive(32'h000A4000, 1'b1, 1'b0, 1'b1, 4'b0100);
    qual = 1'b1;
    repeat (2) @(negedge clk);
    expect_out("R7 late qualifier rise", T_P2, 1'b1, 1'b0);

    // R11: the error flag clears on a clean request
    drive(32'h000B8000, 1'b0, 1'b0, 1'b0, 4'b1100);
    expect_out("R11 lowest of two", T_P2, 1'b1, 1'b1);
    drive(32'h000B8000, 1'b0, 1'b0, 1'b0, 4'b1000);
    expect_out("R11 error clears", T_P3, 1'b1, 1'b0);

    // R12: reset in the middle of a run
    drive(32'h000A0000, 1'b1, 1'b0, 1'b0, 4'b0011);
    #2;
    rst_n = 1'b0;
    #1;
    expect_out("R12 mid-run reset", T_NONE, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule